// File: doc/BRIEF.md
# Three-Wire Serial Register Write Slave

This block accepts register writes from a host over a three-wire control port made of a select line, a serial clock and a serial data line. The three inputs are asynchronous to the block's system clock. Each one passes through a flop synchronizer. Rising edges of the serial clock are found on the synchronized copy, so the system clock must run at least four times faster than the serial clock. The serial clock may run at up to 7 MHz.

While the select line is at its active level, the slave shifts in a 16-bit frame. The first bit received is the most significant bit of the frame. When the sixteenth bit arrives, the frame is judged. If the frame is accepted, its data byte goes into a 32-entry register file and a one-cycle write strobe carries the address and the data. If the frame is rejected, a one-cycle error pulse is raised instead.

A static strap input sets two things at once: the active level of the select line, and the chip address the slave answers to. The port only supports writes; read frames are refused. An active-low power-down input clears the whole register file to zero.

Top module: `ctlwr_slave`

## Requirements
- R1: A frame is 16 bits long and is received MSB first. Frame bits 15:14 hold the chip address, bit 13 is the direction bit, bits 12:8 hold the register address and bits 7:0 hold the data byte.
- R2: When the 16th synchronized serial-clock rising edge of an accepted frame is seen, `wr_stb` is high for exactly one cycle with `wr_addr`/`wr_data` taken from the frame. On the next cycle, the byte for that address in `reg_image` (bits addr*8+7 down to addr*8) holds the data.
- R3: With `cs_strap` low, the select line is active low and the slave accepts chip address 2'b10.
- R4: With `cs_strap` high, the select line is active high and the slave accepts chip address 2'b01.
- R5: A complete frame whose direction bit is 0 (a read) writes nothing and raises `frame_err` for one cycle.
- R6: A complete frame whose chip address differs from the one set by the strap writes nothing and raises `frame_err` for one cycle.
- R7: If the select line goes inactive before 16 bits have arrived, nothing is written, no strobe or error is produced, and the next frame is counted from bit one.
- R8: Serial clock edges after the 16th, while the select line stays active, have no effect on the registers, the strobe or the error output.
- R9: While `pwr_dn_n` is low, and after a synchronous reset, every register reads as zero in `reg_image`.
- R10: `wr_stb` and `frame_err` are never high in the same cycle, and each is at most one cycle long per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_n | input | 1 | Active-low power-down; clears registers and frame state |
| cs_strap | input | 1 | Static strap: 0 = select active low and chip address 10; 1 = select active high and chip address 01 |
| sel_in | input | 1 | Serial select line (asynchronous) |
| sclk_in | input | 1 | Serial clock (asynchronous) |
| sdat_in | input | 1 | Serial data in (asynchronous) |
| wr_stb | output | 1 | One-cycle pulse when a write is committed |
| wr_addr | output | 5 | Register address of the committed write |
| wr_data | output | 8 | Data byte of the committed write |
| frame_err | output | 1 | One-cycle pulse when a complete frame is rejected |
| reg_image | output | 256 | Register file contents; entry n at bits n*8+7:n*8 |

## Verification
The inline assertions check, on every cycle, that the strobe and the error pulse never overlap and never last two cycles. They also check that the bit counter stops at sixteen, that a strobe only appears with a full count, that a committed write lands in the addressed entry on the next cycle, and that power-down leaves the register file empty. Only the bench's scenarios can show the frame decode as a whole. That means: which chip address each strap value accepts, the effect of the select polarity, the refusal of read frames, truncated frames, trailing clocks, and that no other entry of the register file is disturbed. The bench checks these against a byte model of the register file, over directed frames and random frames with random strap values.

// File: rtl/ctlwr_pkg.sv
package ctlwr_pkg;

    localparam int CHIP_W    = 2;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 8;
    localparam int FRAME_W   = CHIP_W + 1 + ADDR_W + DATA_W;
    localparam int REG_DEPTH = 1 << ADDR_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1);

    // Field layout of a received frame, first bit received at the MSB
    typedef struct packed {
        logic [CHIP_W-1:0] chip;
        logic              is_write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        VERDICT_NONE   = 2'd0,
        VERDICT_WRITE  = 2'd1,
        VERDICT_REJECT = 2'd2
    } verdict_e;

    function automatic logic [CHIP_W-1:0] chip_for_strap(input logic strap);
        return strap ? 2'b01 : 2'b10;
    endfunction

    function automatic logic sel_is_active(input logic strap, input logic sel);
        return strap ? sel : ~sel;
    endfunction

    function automatic verdict_e judge(input frame_t f, input logic strap);
        if (f.is_write && (f.chip == chip_for_strap(strap)))
            return VERDICT_WRITE;
        return VERDICT_REJECT;
    endfunction

endpackage

// File: rtl/ctlwr_sync.sv
module ctlwr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[g] <= '0;
            else     pipe[g] <= pipe[g-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/ctlwr_frame.sv
module ctlwr_frame
    import ctlwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n,
    input  logic              strap,
    input  logic              sel_s,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic              stb,
    output logic              err,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    logic               sclk_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] shreg_q;

    logic               active;
    logic               rise;
    logic               take;
    logic               last;
    logic [FRAME_W-1:0] next_bits;
    frame_t             next_frame;
    verdict_e           verdict;

    always_comb begin
        active     = sel_is_active(strap, sel_s);
        rise       = sclk_s & ~sclk_d;
        take       = active && rise && (cnt_q < CNT_W'(FRAME_W));
        last       = take && (cnt_q == CNT_W'(FRAME_W - 1));
        next_bits  = {shreg_q[FRAME_W-2:0], sdat_s};
        next_frame = frame_t'(next_bits);
        verdict    = last ? judge(next_frame, strap) : VERDICT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst || !pd_n) begin
            sclk_d  <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
            stb     <= 1'b0;
            err     <= 1'b0;
            addr    <= '0;
            data    <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (!active) begin
                cnt_q <= '0;
            end else if (take) begin
                cnt_q   <= cnt_q + CNT_W'(1);
                shreg_q <= next_bits;
            end
            stb <= (verdict == VERDICT_WRITE);
            err <= (verdict == VERDICT_REJECT);
            if (verdict == VERDICT_WRITE) begin
                addr <= next_frame.addr;
                data <= next_frame.data;
            end
        end
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst || !pd_n)
        cnt_q <= CNT_W'(FRAME_W));

    // R2
    stb_full_count_chk: assert property (@(posedge clk) disable iff (rst || !pd_n)
        stb |-> (cnt_q == CNT_W'(FRAME_W)));

    // R10
    stb_err_excl_chk: assert property (@(posedge clk) disable iff (rst || !pd_n)
        !(stb && err));

    // R10
    stb_single_chk: assert property (@(posedge clk) disable iff (rst || !pd_n)
        stb |=> !stb);

    // R10
    err_single_chk: assert property (@(posedge clk) disable iff (rst || !pd_n)
        err |=> !err);

endmodule

// File: rtl/ctlwr_regfile.sv
module ctlwr_regfile
    import ctlwr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pd_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [REG_DEPTH*DATA_W-1:0] image
);

    logic [REG_DEPTH-1:0][DATA_W-1:0] regs_q;

    for (genvar e = 0; e < REG_DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst || !pd_n)
                regs_q[e] <= '0;
            else if (we && (waddr == ADDR_W'(e)))
                regs_q[e] <= wdata;
        end
    end

    assign image = regs_q;

    // R9
    pd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !pd_n |=> (image == '0));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst || !pd_n)
        we |=> (regs_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/ctlwr_slave.sv
module ctlwr_slave
    import ctlwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pwr_dn_n,
    input  logic                        cs_strap,
    input  logic                        sel_in,
    input  logic                        sclk_in,
    input  logic                        sdat_in,
    output logic                        wr_stb,
    output logic [ADDR_W-1:0]           wr_addr,
    output logic [DATA_W-1:0]           wr_data,
    output logic                        frame_err,
    output logic [REG_DEPTH*DATA_W-1:0] reg_image
);

    logic [2:0] pins_s;

    ctlwr_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sel_in, sclk_in, sdat_in}),
        .q   (pins_s)
    );

    ctlwr_frame u_frame (
        .clk    (clk),
        .rst    (rst),
        .pd_n   (pwr_dn_n),
        .strap  (cs_strap),
        .sel_s  (pins_s[2]),
        .sclk_s (pins_s[1]),
        .sdat_s (pins_s[0]),
        .stb    (wr_stb),
        .err    (frame_err),
        .addr   (wr_addr),
        .data   (wr_data)
    );

    ctlwr_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .pd_n  (pwr_dn_n),
        .we    (wr_stb),
        .waddr (wr_addr),
        .wdata (wr_data),
        .image (reg_image)
    );

endmodule

// File: tb/tb_ctlwr_slave.sv
module tb_ctlwr_slave;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pwr_dn_n = 1'b1;
    logic         cs_strap = 1'b0;
    logic         sel_in = 1'b1;
    logic         sclk_in = 1'b0;
    logic         sdat_in = 1'b0;
    logic         wr_stb;
    logic [4:0]   wr_addr;
    logic [7:0]   wr_data;
    logic         frame_err;
    logic [255:0] reg_image;

    logic [255:0] model = '0;
    int checks = 0;
    int failures = 0;
    int stb_seen = 0;
    int err_seen = 0;
    logic [4:0] last_a = '0;
    logic [7:0] last_d = '0;

    always #2 clk = ~clk;

    ctlwr_slave dut (
        .clk(clk), .rst(rst), .pwr_dn_n(pwr_dn_n), .cs_strap(cs_strap),
        .sel_in(sel_in), .sclk_in(sclk_in), .sdat_in(sdat_in),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_err(frame_err), .reg_image(reg_image)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_seen++;
            last_a = wr_addr;
            last_d = wr_data;
        end
        if (frame_err) err_seen++;
        if (wr_stb && frame_err) begin
            failures++;
            $display("FAIL R10 strobe and error together: actual=1 expected=0");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [1:0] c, input logic w,
                                       input logic [4:0] a, input logic [7:0] d);
        return {c, w, a, d};
    endfunction

    function automatic logic [1:0] want_chip(input logic p);
        return p ? 2'b01 : 2'b10;
    endfunction

    task automatic set_strap(input logic p);
        cs_strap = p;
        sel_in   = ~p;
        tick(10);
    endtask

    task automatic pulse_bit(input logic b);
        sdat_in = b;
        tick(4);
        sclk_in = 1'b1;
        tick(4);
        sclk_in = 1'b0;
    endtask

    // Sends nbits bits of f followed by extra trailing clocks, then checks
    task automatic send(input string req, input logic [15:0] f, input int nbits, input int extra);
        int s0 = stb_seen;
        int e0 = err_seen;
        bit accept;
        bit full;
        full   = (nbits == 16);
        accept = full && f[13] && (f[15:14] == want_chip(cs_strap));
        sel_in = cs_strap;
        tick(4);
        for (int i = 0; i < nbits; i++) pulse_bit(f[15-i]);
        for (int i = 0; i < extra; i++) pulse_bit(1'($urandom));
        tick(4);
        sel_in = ~cs_strap;
        tick(10);
        if (accept) model[f[12:8]*8 +: 8] = f[7:0];
        check({req, " strobe count"}, 256'(stb_seen - s0), 256'(accept ? 1 : 0));
        check({req, " error count"}, 256'(err_seen - e0), 256'((full && !accept) ? 1 : 0));
        check({req, " register image"}, reg_image, model);
        if (accept)
            check({req, " strobe addr/data"}, 256'({last_a, last_d}), 256'({f[12:8], f[7:0]}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        tick(5);
        rst = 1'b0;
        tick(5);
        // R9 reset state
        check("R9 reset image", reg_image, '0);
        check("R10 idle outputs", 256'({wr_stb, frame_err}), 256'(0));

        // R3 strap low, active-low select, chip 10
        set_strap(1'b0);
        send("R1 R3 write addr 0", mk(2'b10, 1'b1, 5'd0, 8'hA5), 16, 0);
        send("R1 R2 write addr 31", mk(2'b10, 1'b1, 5'd31, 8'hFF), 16, 0);
        send("R6 wrong chip strap low", mk(2'b01, 1'b1, 5'd3, 8'h3C), 16, 0);
        send("R5 read frame", mk(2'b10, 1'b0, 5'd4, 8'h77), 16, 0);
        send("R7 truncated 15", mk(2'b10, 1'b1, 5'd5, 8'h11), 15, 0);
        send("R7 following frame", mk(2'b10, 1'b1, 5'd6, 8'h22), 16, 0);
        send("R8 trailing clocks", mk(2'b10, 1'b1, 5'd7, 8'h5A), 16, 5);

        // R4 strap high, active-high select, chip 01
        set_strap(1'b1);
        send("R4 write addr 9", mk(2'b01, 1'b1, 5'd9, 8'hC3), 16, 0);
        send("R6 wrong chip strap high", mk(2'b10, 1'b1, 5'd10, 8'h99), 16, 0);
        send("R7 truncated 1", mk(2'b01, 1'b1, 5'd11, 8'h44), 1, 0);
        send("R8 trailing 16 clocks", mk(2'b01, 1'b1, 5'd12, 8'h81), 16, 16);

        // R9 power-down clears everything
        pwr_dn_n = 1'b0;
        tick(3);
        check("R9 image during power-down", reg_image, '0);
        pwr_dn_n = 1'b1;
        model = '0;
        tick(3);
        check("R9 image after power-down", reg_image, '0);
        send("R2 write after power-down", mk(2'b01, 1'b1, 5'd1, 8'h0F), 16, 0);

        // Random frames with random strap values
        for (int k = 0; k < 80; k++) begin
            logic [1:0] c;
            logic       w;
            int         nb;
            int         ex;
            if ((k % 8) == 0) set_strap(1'($urandom));
            c  = ($urandom % 4 != 0) ? want_chip(cs_strap) : 2'($urandom);
            w  = ($urandom % 5 != 0);
            nb = ($urandom % 6 == 0) ? int'($urandom % 16) : 16;
            ex = ($urandom % 4 == 0) ? int'($urandom % 4) : 0;
            send("R1 R2 random frame", mk(c, w, 5'($urandom), 8'($urandom)), nb, ex);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule